// File: doc/BRIEF.md
# Diskette Head Positioning Timer

This block sequences the read/write head of a diskette drive pair. Software issues single-track step commands (inward or outward) and a load/settle command. The block raises the head-load solenoid, emits a step pulse with a direction level, and keeps the controller busy for the step lockout. It tracks when the head has settled well enough for a data transfer. After a period with no commands the head is lifted again. The head is also lifted at once when the unit is deselected or the selected unit number changes.

Every interval is given in milliseconds and converted to master-clock cycles through a ticks-per-millisecond parameter. A single "ready deadline" collects all settle obligations: head load, settle after a step, and settle after a unit change. Each new obligation can only push the deadline later. A command is accepted only when the block is idle and the unit selection is stable. A command that is refused sets a sticky illegal flag and leaves the operation in progress untouched. The block pulses done when each accepted command finishes, and pulses an interrupt request when a step finishes.

Top module: `head_pos_timer`

## Requirements
- R1: The command code on cmdOp is 2'b01 for a step inward (stepDir becomes 1), 2'b10 for a step outward (stepDir becomes 0), 2'b11 for load/settle, and 2'b00 is reserved. A command is accepted on the rising edge where all of these hold: cmdValid is 1, busy is 0, unitEnable is 1, unitSel equals the unit in effect, and the code is not 2'b00. stepDir holds its value until the next accepted step.
- R2: After an accepted step, busy is 1 from the next cycle for exactly STEP_MS×TICKS_PER_MS cycles. stepPulse is 1 for PULSE_TICKS cycles, starting in the cycle after acceptance.
- R3: done is 1 for exactly one cycle, in the first cycle after busy falls, for every accepted command. irq is 1 together with done only when the finished command was a step.
- R4: Any accepted command drives headLoad to 1 from the next cycle.
- R5: headReady is 1 exactly when headLoad is 1 and the ready deadline has passed. On acceptance at edge n, the deadline becomes the later of the old deadline and n plus a need. The need is (STEP_MS+SETTLE_MS)×TICKS_PER_MS for a step and SETTLE_MS×TICKS_PER_MS for load/settle. If headLoad was 0 before the edge, the need is raised to at least LOAD_MS×TICKS_PER_MS.
- R6: An accepted load/settle command keeps busy high until the ready deadline is reached. busy falls in the same cycle that the deadline allows headReady.
- R7: When unitSel differs from the unit in effect, these happen at the next edge: the new unit takes effect, headLoad drops to 0, and the ready deadline becomes that edge plus UNIT_MS×TICKS_PER_MS. A command presented in that cycle is refused.
- R8: While unitEnable is 0, headLoad is 0 from the next cycle and every command is refused.
- R9: If no command is accepted, headLoad falls exactly UNLOAD_MS×TICKS_PER_MS cycles after busy falls. A command accepted on the very edge of expiry keeps the head loaded.
- R10: A refused command sets illegalCmd from the next cycle. Commands are refused for any of four reasons: busy, reserved code, deselected unit, or unit change. illegalCmd stays set until the next accepted command clears it. A refused command does not change busy, done, irq, stepPulse, headLoad or headReady.
- R11: While rstN is low, every output is 0 and the unit in effect is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rstN | input | 1 | Asynchronous active-low reset |
| cmdValid | input | 1 | Command presented this cycle |
| cmdOp | input | 2 | Command code (see R1) |
| unitSel | input | 1 | Selected unit number |
| unitEnable | input | 1 | Unit is selected (0 lifts the head) |
| stepPulse | output | 1 | Step pulse to the drive |
| stepDir | output | 1 | Step direction, 1 = inward |
| headLoad | output | 1 | Head-load solenoid drive |
| headReady | output | 1 | Head loaded and settled |
| busy | output | 1 | Command in progress |
| done | output | 1 | One-cycle completion pulse |
| irq | output | 1 | One-cycle interrupt request after a step |
| illegalCmd | output | 1 | Sticky refused-command flag |

## Verification
The hardest situations to reach are those where two obligations overlap. One is a pending unit-change settle that is longer than the need of a following command, so the old deadline must win. The other is a command that lands on the exact edge where the idle unload would fire. Directed sequences reach both. The bench toggles the unit and then issues a load/settle command well before the 170 ms window closes. It also times a step so that it is accepted on the cycle the idle count expires. Seeded random stimulus adds long idle gaps, deselection and commands sent while busy. A cycle-level timestamp model checks every output after every edge.

// File: rtl/hpt_pkg.sv
package hpt_pkg;

  typedef enum logic [1:0] {
    OP_NONE     = 2'b00,
    OP_STEP_IN  = 2'b01,
    OP_STEP_OUT = 2'b10,
    OP_SETTLE   = 2'b11
  } hptOp_e;

  // strobes from control to datapath
  typedef struct packed {
    logic accept;
    logic isStep;
  } hptStrobe_t;

  function automatic int maxOf(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/hpt_datapath.sv
module hpt_datapath
  import hpt_pkg::*;
#(
  parameter int STEP_CYC   = 40,
  parameter int SETTLE_CYC = 40,
  parameter int LOAD_CYC   = 240,
  parameter int UNIT_CYC   = 680,
  parameter int UNLOAD_CYC = 1280,
  parameter int PULSE_CYC  = 2,
  parameter int CW         = 11
) (
  input  logic       clk,
  input  logic       rstN,
  input  hptStrobe_t strobe,
  input  logic       unitSel,
  input  logic       unitEnable,
  input  logic       busy,
  input  logic       headLoad,
  output logic       unitChange,
  output logic       busyExpire,
  output logic       idleExpire,
  output logic       readyZero,
  output logic       stepPulse
);

  localparam logic [CW-1:0] STEP_V    = CW'(STEP_CYC);
  localparam logic [CW-1:0] SETTLE_V  = CW'(SETTLE_CYC);
  localparam logic [CW-1:0] STEPSET_V = CW'(STEP_CYC + SETTLE_CYC);
  localparam logic [CW-1:0] LOAD_V    = CW'(LOAD_CYC);
  localparam logic [CW-1:0] UNIT_V    = CW'(UNIT_CYC);
  localparam logic [CW-1:0] UNLOAD_V  = CW'(UNLOAD_CYC);
  localparam logic [CW-1:0] PULSE_V   = CW'(PULSE_CYC);

  logic [CW-1:0] readyCnt, busyCnt, idleCnt, pulseCnt;
  logic [CW-1:0] readyDec, stepReq, reqFloor, readyNew;
  logic          unitReg, countIdle;

  always_comb begin
    readyDec = (readyCnt == '0) ? '0 : readyCnt - CW'(1);
    stepReq  = strobe.isStep ? STEPSET_V : SETTLE_V;
    reqFloor = (!headLoad && (LOAD_V > stepReq)) ? LOAD_V : stepReq;
    readyNew = (readyDec > reqFloor) ? readyDec : reqFloor;
  end

  assign unitChange = (unitSel != unitReg);
  assign countIdle  = headLoad && !busy && unitEnable;
  assign busyExpire = (busyCnt == CW'(1));
  assign idleExpire = countIdle && (idleCnt == CW'(1));
  assign readyZero  = (readyCnt == '0);
  assign stepPulse  = (pulseCnt != '0);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      unitReg  <= 1'b0;
      readyCnt <= '0;
      busyCnt  <= '0;
      idleCnt  <= '0;
      pulseCnt <= '0;
    end else begin
      unitReg <= unitSel;

      if (unitChange)        readyCnt <= UNIT_V;
      else if (strobe.accept) readyCnt <= readyNew;
      else                   readyCnt <= readyDec;

      if (strobe.accept)       busyCnt <= strobe.isStep ? STEP_V : readyNew;
      else if (busyCnt != '0)  busyCnt <= busyCnt - CW'(1);

      if (strobe.accept)                    idleCnt <= UNLOAD_V;
      else if (countIdle && idleCnt != '0)  idleCnt <= idleCnt - CW'(1);

      if (strobe.accept && strobe.isStep)   pulseCnt <= PULSE_V;
      else if (pulseCnt != '0)              pulseCnt <= pulseCnt - CW'(1);
    end
  end

endmodule

// File: rtl/hpt_control.sv
module hpt_control
  import hpt_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       cmdValid,
  input  logic [1:0] cmdOp,
  input  logic       unitEnable,
  input  logic       unitChange,
  input  logic       busyExpire,
  input  logic       idleExpire,
  output hptStrobe_t strobe,
  output logic       busy,
  output logic       done,
  output logic       irq,
  output logic       stepDir,
  output logic       headLoad,
  output logic       illegalCmd
);

  hptOp_e op;
  logic   accept, isStep, lastStep;

  assign op     = hptOp_e'(cmdOp);
  assign accept = cmdValid && !busy && unitEnable && !unitChange && (op != OP_NONE);
  assign isStep = (op == OP_STEP_IN) || (op == OP_STEP_OUT);

  assign strobe.accept = accept;
  assign strobe.isStep = isStep;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busy       <= 1'b0;
      done       <= 1'b0;
      irq        <= 1'b0;
      stepDir    <= 1'b0;
      headLoad   <= 1'b0;
      illegalCmd <= 1'b0;
      lastStep   <= 1'b0;
    end else begin
      done <= busyExpire;
      irq  <= busyExpire && lastStep;

      if (accept)          busy <= 1'b1;
      else if (busyExpire) busy <= 1'b0;

      if (accept) begin
        lastStep <= isStep;
        if (isStep) stepDir <= (op == OP_STEP_IN);
      end

      if (!unitEnable || unitChange) headLoad <= 1'b0;
      else if (accept)               headLoad <= 1'b1;
      else if (idleExpire)           headLoad <= 1'b0;

      if (accept)        illegalCmd <= 1'b0;
      else if (cmdValid) illegalCmd <= 1'b1;
    end
  end

endmodule

// File: rtl/head_pos_timer.sv
module head_pos_timer
  import hpt_pkg::*;
#(
  parameter int TICKS_PER_MS = 4,
  parameter int STEP_MS      = 10,
  parameter int SETTLE_MS    = 10,
  parameter int LOAD_MS      = 60,
  parameter int UNIT_MS      = 170,
  parameter int UNLOAD_MS    = 320,
  parameter int PULSE_TICKS  = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       cmdValid,
  input  logic [1:0] cmdOp,
  input  logic       unitSel,
  input  logic       unitEnable,
  output logic       stepPulse,
  output logic       stepDir,
  output logic       headLoad,
  output logic       headReady,
  output logic       busy,
  output logic       done,
  output logic       irq,
  output logic       illegalCmd
);

  localparam int STEP_CYC   = STEP_MS * TICKS_PER_MS;
  localparam int SETTLE_CYC = SETTLE_MS * TICKS_PER_MS;
  localparam int LOAD_CYC   = LOAD_MS * TICKS_PER_MS;
  localparam int UNIT_CYC   = UNIT_MS * TICKS_PER_MS;
  localparam int UNLOAD_CYC = UNLOAD_MS * TICKS_PER_MS;
  localparam int MAX_CYC    = maxOf(maxOf(maxOf(STEP_CYC + SETTLE_CYC, LOAD_CYC),
                                          maxOf(UNIT_CYC, UNLOAD_CYC)), PULSE_TICKS);
  localparam int CW         = $clog2(MAX_CYC + 1);

  hptStrobe_t strobe;
  logic       unitChange, busyExpire, idleExpire, readyZero;

  hpt_control u_control (
    .clk        (clk),
    .rstN       (rstN),
    .cmdValid   (cmdValid),
    .cmdOp      (cmdOp),
    .unitEnable (unitEnable),
    .unitChange (unitChange),
    .busyExpire (busyExpire),
    .idleExpire (idleExpire),
    .strobe     (strobe),
    .busy       (busy),
    .done       (done),
    .irq        (irq),
    .stepDir    (stepDir),
    .headLoad   (headLoad),
    .illegalCmd (illegalCmd)
  );

  hpt_datapath #(
    .STEP_CYC   (STEP_CYC),
    .SETTLE_CYC (SETTLE_CYC),
    .LOAD_CYC   (LOAD_CYC),
    .UNIT_CYC   (UNIT_CYC),
    .UNLOAD_CYC (UNLOAD_CYC),
    .PULSE_CYC  (PULSE_TICKS),
    .CW         (CW)
  ) u_datapath (
    .clk        (clk),
    .rstN       (rstN),
    .strobe     (strobe),
    .unitSel    (unitSel),
    .unitEnable (unitEnable),
    .busy       (busy),
    .headLoad   (headLoad),
    .unitChange (unitChange),
    .busyExpire (busyExpire),
    .idleExpire (idleExpire),
    .readyZero  (readyZero),
    .stepPulse  (stepPulse)
  );

  assign headReady = headLoad && readyZero;

endmodule

// File: rtl/head_pos_timer_chk.sv
module head_pos_timer_chk (
  input logic       clk,
  input logic       rstN,
  input logic       cmdValid,
  input logic       unitEnable,
  input logic       unitChange,
  input logic       accepted,
  input logic       stepPulse,
  input logic       headLoad,
  input logic       headReady,
  input logic       busy,
  input logic       done,
  input logic       irq,
  input logic       illegalCmd
);

  p_pulse_in_busy_r2: assert property (@(posedge clk) disable iff (!rstN)
    stepPulse |-> busy);

  p_done_after_busy_r3: assert property (@(posedge clk) disable iff (!rstN)
    done |-> ($past(busy) && !busy));

  p_irq_with_done_r3: assert property (@(posedge clk) disable iff (!rstN)
    irq |-> done);

  p_accept_loads_r4: assert property (@(posedge clk) disable iff (!rstN)
    accepted |=> (busy && headLoad && !illegalCmd));

  p_ready_needs_load_r5: assert property (@(posedge clk) disable iff (!rstN)
    headReady |-> headLoad);

  p_unit_change_r7: assert property (@(posedge clk) disable iff (!rstN)
    unitChange |=> (!headLoad && !headReady));

  p_deselect_unload_r8: assert property (@(posedge clk) disable iff (!rstN)
    !unitEnable |=> !headLoad);

  p_busy_reject_r10: assert property (@(posedge clk) disable iff (!rstN)
    (cmdValid && busy) |=> illegalCmd);

endmodule

bind head_pos_timer head_pos_timer_chk u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .cmdValid   (cmdValid),
  .unitEnable (unitEnable),
  .unitChange (unitChange),
  .accepted   (strobe.accept),
  .stepPulse  (stepPulse),
  .headLoad   (headLoad),
  .headReady  (headReady),
  .busy       (busy),
  .done       (done),
  .irq        (irq),
  .illegalCmd (illegalCmd)
);

// File: tb/head_pos_timer_bench.sv
`timescale 1ns/1ps
module head_pos_timer_bench;

  localparam int     TPM    = 4;
  localparam longint STEP   = 10 * TPM;
  localparam longint SETTLE = 10 * TPM;
  localparam longint LOADT  = 60 * TPM;
  localparam longint UNITT  = 170 * TPM;
  localparam longint UNLOAD = 320 * TPM;
  localparam longint PULSE  = 2;

  logic       clk = 1'b0, rstN = 1'b0, cmdValid = 1'b0;
  logic [1:0] cmdOp = 2'b00;
  logic       unitSel = 1'b0, unitEnable = 1'b1;
  logic       stepPulse, stepDir, headLoad, headReady, busy, done, irq, illegalCmd;

  head_pos_timer u_head_pos_timer (
    .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .cmdOp(cmdOp),
    .unitSel(unitSel), .unitEnable(unitEnable), .stepPulse(stepPulse),
    .stepDir(stepDir), .headLoad(headLoad), .headReady(headReady),
    .busy(busy), .done(done), .irq(irq), .illegalCmd(illegalCmd)
  );

  always #2.5 clk = ~clk;

  int  checks = 0, failures = 0;
  bit  finished = 1'b0;

  // timestamp reference model: values are edge numbers
  longint cyc = 0;
  longint mBusyEnd = -1, mReadyAt = -1, mPulseEnd = -1, mIdleAt = -1;
  bit     mHead = 0, mUnit = 0, mIll = 0, mWasStep = 0, mDir = 0;

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d at edge %0d", req, what, act, exp, cyc);
    end
  endtask

  always @(posedge clk) begin
    longint n, req;
    bit busyPre, chg, acc, isStep;
    n = cyc + 1;
    if (!rstN) begin
      mBusyEnd = -1; mReadyAt = -1; mPulseEnd = -1; mIdleAt = -1;
      mHead = 0; mUnit = 0; mIll = 0; mWasStep = 0; mDir = 0;
    end else begin
      busyPre = (cyc < mBusyEnd);
      chg     = (unitSel != mUnit);
      acc     = cmdValid && !busyPre && unitEnable && !chg && (cmdOp != 2'b00);
      if (acc) begin
        isStep = (cmdOp != 2'b11);
        req = isStep ? STEP + SETTLE : SETTLE;
        if (!mHead && req < LOADT) req = LOADT;
        if (n + req > mReadyAt) mReadyAt = n + req;
        mBusyEnd = n + (isStep ? STEP : mReadyAt - n);
        mWasStep = isStep;
        if (isStep) begin mPulseEnd = n + PULSE; mDir = (cmdOp == 2'b01); end
        mIdleAt = mBusyEnd + UNLOAD;
        mHead = 1; mIll = 0;
      end else begin
        if (cmdValid) mIll = 1;
        if (mHead && n == mIdleAt) mHead = 0;
      end
      if (!unitEnable || chg) mHead = 0;
      if (chg) begin mReadyAt = n + UNITT; mUnit = unitSel; end
    end
    cyc = n;
  end

  // per-cycle comparison against the model
  always @(negedge clk) begin
    bit eDone;
    if (rstN && !finished) begin
      eDone = (cyc == mBusyEnd);
      check(busy == (cyc < mBusyEnd), "R2 R6", "busy", busy, cyc < mBusyEnd);
      check(done == eDone, "R3", "done", done, eDone);
      check(irq == (eDone && mWasStep), "R3", "irq", irq, eDone && mWasStep);
      check(stepPulse == (cyc < mPulseEnd), "R2", "stepPulse", stepPulse, cyc < mPulseEnd);
      check(stepDir == mDir, "R1", "stepDir", stepDir, mDir);
      check(headLoad == mHead, "R4 R7 R8 R9", "headLoad", headLoad, mHead);
      check(headReady == (mHead && cyc >= mReadyAt), "R5", "headReady", headReady,
            mHead && cyc >= mReadyAt);
      check(illegalCmd == mIll, "R10", "illegalCmd", illegalCmd, mIll);
    end
  end

  task automatic issue(input logic [1:0] op);
    @(negedge clk); cmdValid = 1'b1; cmdOp = op;
    @(negedge clk); cmdValid = 1'b0; cmdOp = 2'b00;
  endtask

  task automatic finishRun();
    if (!finished) begin
      finished = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    if (cyc > 190000 && !finished) begin
      failures++;
      $display("FAIL watchdog all requirements actual=%0d expected<190000", cyc);
      finishRun();
    end
  end

  initial begin
    longint t0, tb;
    void'($urandom(32'd4242));
    repeat (4) @(negedge clk);
    // R11: reset state
    check({stepPulse, stepDir, headLoad, headReady, busy, done, irq, illegalCmd} == 8'h00,
          "R11", "outputs in reset", {stepPulse, stepDir, headLoad, headReady, busy, done,
          irq, illegalCmd}, 0);
    rstN = 1'b1;
    repeat (3) @(negedge clk);

    // R2 R5: step inward from unloaded head
    issue(2'b01);
    t0 = cyc;
    check(stepDir == 1'b1, "R1", "stepDir after step in", stepDir, 1);
    while (busy) @(negedge clk);
    check(cyc - t0 == STEP, "R2", "busy length", cyc - t0, STEP);
    while (!headReady) @(negedge clk);
    check(cyc - t0 == LOADT, "R5", "ready after load", cyc - t0, LOADT);

    // R10: command during busy refused, busy length kept
    issue(2'b10);
    t0 = cyc;
    issue(2'b01);
    check(illegalCmd == 1'b1, "R10", "illegal while busy", illegalCmd, 1);
    while (busy) @(negedge clk);
    check(cyc - t0 == STEP, "R10", "busy undisturbed", cyc - t0, STEP);
    check(stepDir == 1'b0, "R1", "stepDir after step out", stepDir, 0);

    // R1: reserved code refused
    issue(2'b11);
    while (busy) @(negedge clk);
    issue(2'b00);
    check(illegalCmd == 1'b1, "R1", "reserved code refused", illegalCmd, 1);

    // R9: idle unload timing
    tb = mBusyEnd;
    while (headLoad) @(negedge clk);
    check(cyc - tb == UNLOAD, "R9", "unload delay", cyc - tb, UNLOAD);

    // R9: command on the expiry edge keeps the head loaded
    issue(2'b01);
    while (busy) @(negedge clk);
    repeat (UNLOAD - 2) @(negedge clk);
    issue(2'b01);
    check(headLoad == 1'b1, "R9", "head kept at expiry", headLoad, 1);

    // R7: unit change, then pending 170 ms deadline dominates
    while (busy) @(negedge clk);
    @(negedge clk); unitSel = 1'b1; cmdValid = 1'b1; cmdOp = 2'b11;
    @(negedge clk); cmdValid = 1'b0; cmdOp = 2'b00;
    t0 = cyc;
    check(headLoad == 1'b0 && illegalCmd == 1'b1, "R7", "unit change unload/refuse",
          {headLoad, illegalCmd}, 1);
    repeat (10) @(negedge clk);
    issue(2'b11);
    while (!headReady) @(negedge clk);
    check(cyc - t0 == UNITT, "R7", "unit settle", cyc - t0, UNITT);

    // R8: deselect
    @(negedge clk); unitEnable = 1'b0;
    @(negedge clk);
    check(headLoad == 1'b0, "R8", "deselect unload", headLoad, 0);
    issue(2'b01);
    check(busy == 1'b0, "R8", "refused while deselected", busy, 0);
    unitEnable = 1'b1;

    // random phase
    for (int i = 0; i < 350; i++) begin
      int r;
      r = $urandom_range(0, 99);
      if (r < 60) begin
        issue(2'($urandom_range(0, 3)));
        repeat ($urandom_range(0, 60)) @(negedge clk);
      end else if (r < 75) begin
        repeat ($urandom_range(200, 1500)) @(negedge clk);
      end else if (r < 85) begin
        @(negedge clk); unitSel = ~unitSel;
        if ($urandom_range(0, 1) == 1) begin cmdValid = 1'b1; cmdOp = 2'b01; end
        @(negedge clk); cmdValid = 1'b0; cmdOp = 2'b00;
      end else if (r < 93) begin
        @(negedge clk); unitEnable = 1'b0;
        repeat ($urandom_range(1, 5)) @(negedge clk);
        unitEnable = 1'b1;
      end else begin
        issue(2'b01);
        issue(2'b10);
        issue(2'b11);
      end
    end
    repeat (20) @(negedge clk);
    finishRun();
  end

endmodule